// File: doc/BRIEF.md
# Ping-Pong Integrate-and-Dump Correlator Channel

This block is one digital measurement channel of a compressive receiver. Each clock it takes one signed input sample, flips its sign or leaves it according to a one-bit chip value, and adds the result into a running sum. The sum covers a fixed frame of 52 clocks. A frame strobe marks the first sample of every frame. At that strobe the sum of the frame that just ended is copied into a hold register, which a downstream converter or consumer can read during a valid window of 26 clocks.

Two accumulators share the work. A select input decides which one integrates and which one is cleared. The surrounding logic toggles select at every frame strobe. The accumulator that has just finished is read at the strobe and then cleared during the next frame, while the other one starts on the new frame in the same clock. Because of this, no sample is ever lost at a frame boundary. A frame-spacing monitor checks that strobes arrive exactly 52 clocks apart and raises a sticky error flag if they do not.

Top module: `pp_integrate_dump`

## Requirements
- R1: A sample taken while `chipIn` is 1 adds +sample to the frame sum. A sample taken while `chipIn` is 0 adds −sample.
- R2: A frame sum holds the sample of the strobe cycle and the 51 samples after it. It does not hold the sample of the next strobe cycle.
- R3: While `selIn` is 1, accumulator A is cleared and accumulator B integrates. While `selIn` is 0, B is cleared and A integrates. At a strobe the idle accumulator is the one captured. Frames integrated in A and frames integrated in B both give correct sums.
- R4: `measOut` takes the new frame sum on the clock edge that samples `frameStrobe` high. It holds its value on every edge where `frameStrobe` is low.
- R5: After a capture, `measValid` is high for exactly 26 cycles, beginning with the cycle after the capture edge. At all other times it is low.
- R6: The first strobe after reset does not raise `measValid`, because no complete frame comes before it.
- R7: The accumulator is SAMPLE_W+6 bits wide, 18 bits by default. A frame of 52 full-scale samples, ±2048·52 = ±106496, is reported exactly, with no wrap.
- R8: With strobes 52 clocks apart, every sample goes into exactly one reported frame sum.
- R9: After the first strobe, a strobe that comes earlier or later than 52 clocks after the previous one sets `seqError`. `seqError` then stays set until reset.
- R10: During and right after reset, `measOut` is 0, `measValid` is 0 and `seqError` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | SAMPLE_W | Signed two's-complement input sample |
| chipIn | input | 1 | Chip value: 1 means +1, 0 means −1 |
| frameStrobe | input | 1 | High on the first sample of each frame |
| selIn | input | 1 | Accumulator select: 1 means B integrates and A clears |
| measOut | output | SAMPLE_W+6 | Signed frame sum in the hold register |
| measValid | output | 1 | High during the hold window after a capture |
| seqError | output | 1 | Sticky flag for wrong frame-strobe spacing |

## Verification
Suppose the accumulator that should be clearing keeps an old value, or the wrong accumulator is captured. Then `measOut` is wrong at the very next strobe, so a per-cycle reference sum exposes the fault within one frame. A fault in the hold-window counter shows up as `measValid` falling one cycle too early or too late, at cycle 26 after a capture. The frame-spacing monitor is driven with one early strobe and one missing strobe, and its flag is checked to stay set afterwards.

// File: rtl/pp_pkg.sv
package pp_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // frame boundary: latch idle accumulator into hold register
    logic useB;     // 1: accumulator B integrates, A clears
  } ppStrobes_t;

endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int FRAME_LEN = 52,
  parameter int HOLD_LEN  = 26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameStrobe,
  input  logic       selIn,
  output ppStrobes_t strobes,
  output logic       measValid,
  output logic       seqError
);

  localparam int CNT_W  = $clog2(FRAME_LEN + 1);
  localparam int HOLD_W = $clog2(HOLD_LEN + 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0]  SAT_CNT  = CNT_W'(FRAME_LEN);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_LEN);

  logic [CNT_W-1:0]  frameCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              primed;
  logic              atLast;
  logic              earlyStrobe;
  logic              missedStrobe;

  always_comb begin
    atLast       = (frameCnt == LAST_CNT);
    earlyStrobe  = primed && frameStrobe && !atLast;
    missedStrobe = primed && !frameStrobe && atLast;
    strobes.capture = frameStrobe;
    strobes.useB    = selIn;
    measValid       = (holdCnt != '0);
  end

  // Frame spacing monitor
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frameCnt <= '0;
      primed   <= 1'b0;
      seqError <= 1'b0;
    end else begin
      if (frameStrobe)           frameCnt <= '0;
      else if (frameCnt != SAT_CNT) frameCnt <= frameCnt + CNT_W'(1);
      primed   <= primed | frameStrobe;
      seqError <= seqError | earlyStrobe | missedStrobe;
    end
  end

  // Hold window counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (frameStrobe && primed) begin
      holdCnt <= HOLD_INIT;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       chipIn,
  input  ppStrobes_t                 strobes,
  output logic signed [ACC_W-1:0]    measOut
);

  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ACC_W-1:0] chipped;

  always_comb begin
    sampleExt = {{EXT_W{sampleIn[SAMPLE_W-1]}}, sampleIn};
    chipped   = chipIn ? sampleExt : -sampleExt;
  end

  // Two accumulators: index 0 = A, index 1 = B
  for (genvar g = 0; g < 2; g++) begin : gen_acc
    localparam logic IS_B = (g == 1);
    logic signed [ACC_W-1:0] accReg;
    always_ff @(posedge clk) begin
      if (!rst_n)                    accReg <= '0;
      else if (strobes.useB == IS_B) accReg <= accReg + chipped;
      else                           accReg <= '0;
    end
  end

  // Hold register: capture the idle (just finished) accumulator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      measOut <= '0;
    end else if (strobes.capture) begin
      measOut <= strobes.useB ? gen_acc[0].accReg : gen_acc[1].accReg;
    end
  end

endmodule

// File: rtl/pp_integrate_dump.sv
module pp_integrate_dump
  import pp_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_LEN = 52
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic signed [SAMPLE_W-1:0]                   sampleIn,
  input  logic                                         chipIn,
  input  logic                                         frameStrobe,
  input  logic                                         selIn,
  output logic signed [SAMPLE_W+$clog2(FRAME_LEN)-1:0] measOut,
  output logic                                         measValid,
  output logic                                         seqError
);

  localparam int HOLD_LEN = FRAME_LEN / 2;
  localparam int ACC_W    = SAMPLE_W + $clog2(FRAME_LEN);

  ppStrobes_t strobes;

  pp_ctrl #(
    .FRAME_LEN(FRAME_LEN),
    .HOLD_LEN (HOLD_LEN)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frameStrobe(frameStrobe),
    .selIn      (selIn),
    .strobes    (strobes),
    .measValid  (measValid),
    .seqError   (seqError)
  );

  pp_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sampleIn(sampleIn),
    .chipIn  (chipIn),
    .strobes (strobes),
    .measOut (measOut)
  );

endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int SAMPLE_W  = 12,
  parameter int FRAME_LEN = 52,
  parameter int HOLD_LEN  = 26,
  parameter int ACC_W     = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frameStrobe,
  input logic                    measValid,
  input logic                    seqError,
  input logic signed [ACC_W-1:0] measOut
);

  localparam longint BOUND = longint'(FRAME_LEN) * (longint'(1) <<< (SAMPLE_W - 1));

  logic seenStrobe;
  int   validRun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seenStrobe <= 1'b0;
      validRun   <= 0;
    end else begin
      seenStrobe <= seenStrobe | frameStrobe;
      validRun   <= frameStrobe ? 0 : (measValid ? validRun + 1 : 0);
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStrobe |=> $stable(measOut));

  p_valid_from_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(measValid) |-> $past(frameStrobe));

  p_valid_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    validRun <= HOLD_LEN);

  p_first_unprimed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStrobe && !seenStrobe) |=> !measValid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(measOut) <= BOUND) && (longint'(measOut) >= -BOUND));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seqError |=> seqError);

endmodule

bind pp_integrate_dump pp_checker #(
  .SAMPLE_W (SAMPLE_W),
  .FRAME_LEN(FRAME_LEN),
  .HOLD_LEN (HOLD_LEN),
  .ACC_W    (ACC_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .frameStrobe(frameStrobe),
  .measValid  (measValid),
  .seqError   (seqError),
  .measOut    (measOut)
);

// File: tb/pp_integrate_dump_tb.sv
`timescale 1ns/1ps
module pp_integrate_dump_tb_top;

  localparam int SAMPLE_W = 12;
  localparam int FRAME    = 52;
  localparam int HOLD     = 26;
  localparam int ACC_W    = SAMPLE_W + 6;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic signed [SAMPLE_W-1:0] sampleIn = '0;
  logic                       chipIn = 1'b0;
  logic                       frameStrobe = 1'b0;
  logic                       selIn = 1'b0;
  logic signed [ACC_W-1:0]    measOut;
  logic                       measValid;
  logic                       seqError;

  always #2.5 clk = ~clk;

  pp_integrate_dump #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME)) dut_i (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .chipIn(chipIn),
    .frameStrobe(frameStrobe), .selIn(selIn), .measOut(measOut),
    .measValid(measValid), .seqError(seqError)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  longint curSum, holdExp, lastFrameSum;
  int     validCnt, sinceStrobe;
  bit     primed, errExp, selState;

  task automatic checkVal(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; frameStrobe = 1'b0; sampleIn = '0; chipIn = 1'b0;
    selState = 1'b0; selIn = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    curSum = 0; holdExp = 0; validCnt = 0; sinceStrobe = 0;
    primed = 0; errExp = 0;
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input int s, input bit chip, input bit strobe);
    longint v;
    sampleIn = SAMPLE_W'(s);
    chipIn = chip;
    frameStrobe = strobe;
    if (strobe) selState = !selState;
    selIn = selState;
    v = chip ? longint'(s) : -longint'(s);
    @(posedge clk);
    if (primed && strobe && sinceStrobe != FRAME - 1) errExp = 1;
    if (primed && !strobe && sinceStrobe == FRAME - 1) errExp = 1;
    if (strobe) begin
      holdExp = curSum;
      curSum = v;
      if (primed) validCnt = HOLD;
      sinceStrobe = 0;
      primed = 1;
    end else begin
      curSum += v;
      if (validCnt > 0) validCnt--;
      if (sinceStrobe < FRAME) sinceStrobe++;
    end
    @(negedge clk);
    checkVal("R8 measOut", longint'(measOut), holdExp);
    checkVal("R5 measValid", longint'(measValid), longint'(validCnt > 0));
    checkVal("R9 seqError", longint'(seqError), longint'(errExp));
  endtask

  function automatic int sampleFor(input int mode, input int i);
    case (mode)
      0, 1:    return 3;
      2, 3:    return -2048;
      5:       return (i == 0) ? 100 : ((i == FRAME - 1) ? 7 : 0);
      default: return int'($urandom_range(4095)) - 2048;
    endcase
  endfunction

  function automatic bit chipFor(input int mode);
    case (mode)
      1, 3:    return 1'b0;
      4:       return 1'(($urandom_range(1)));
      default: return 1'b1;
    endcase
  endfunction

  // One full frame; optionally checks the previous frame's result
  task automatic frame(input int mode, input string tag, input bit doChk, input longint expPrev);
    longint sum = 0;
    longint startVal = 0;
    for (int i = 0; i < FRAME; i++) begin
      int s = sampleFor(mode, i);
      bit c = chipFor(mode);
      sum += c ? longint'(s) : -longint'(s);
      step(s, c, i == 0);
      if (doChk) begin
        if (i == 1) begin
          checkVal(tag, longint'(measOut), expPrev);
          startVal = longint'(measOut);
        end
        if (i == HOLD - 1) checkVal("R5 valid last cycle", longint'(measValid), 1);
        if (i == HOLD)     checkVal("R5 valid dropped", longint'(measValid), 0);
        if (i == 40)       checkVal("R4 hold stable", longint'(measOut), startVal);
      end
    end
    lastFrameSum = sum;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    checkVal("R10 measOut", longint'(measOut), 0);
    checkVal("R10 measValid", longint'(measValid), 0);
    checkVal("R10 seqError", longint'(seqError), 0);

    // First frame after reset: no valid window (R6)
    frame(0, "R6", 1'b0, 0);
    checkVal("R6 no valid after first strobe", longint'(measValid), 0);

    frame(1, "R1 chip=1 sum", 1'b1, 156);
    frame(2, "R1 chip=0 sum", 1'b1, -156);
    frame(3, "R7 full-scale negative", 1'b1, -106496);
    frame(5, "R7 full-scale positive", 1'b1, 106496);
    frame(4, "R2 frame edges", 1'b1, 107);
    for (int k = 0; k < 6; k++) frame(4, "R3 alternating accumulators", 1'b1, lastFrameSum);
    frame(0, "R8 gapless random", 1'b1, lastFrameSum);
    checkVal("R9 no error with regular strobes", longint'(seqError), 0);

    // Early strobe
    for (int i = 0; i < 30; i++) step(5, 1'b1, i == 0);
    step(5, 1'b1, 1'b1);
    checkVal("R9 early strobe flagged", longint'(seqError), 1);
    for (int i = 0; i < 60; i++) step(1, 1'b0, 1'b0);
    checkVal("R9 error sticky", longint'(seqError), 1);

    doReset();
    @(negedge clk);
    checkVal("R10 error cleared by reset", longint'(seqError), 0);

    // Missing strobe
    frame(0, "R8", 1'b0, 0);
    frame(1, "R1 after reset", 1'b1, 156);
    for (int i = 0; i < 60; i++) step(2, 1'b1, 1'b0);
    checkVal("R9 missing strobe flagged", longint'(seqError), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule